// File: doc/BRIEF.md
# Colour Bar Test Pattern Source

This block generates a broadcast-style test card one pixel at a time for a video output path. A separate raster timing generator drives it with three strobes: a take strobe for each active pixel the display consumes, an end-of-line pulse on the last pixel of every line, and an end-of-frame pulse on the last pixel of the frame. It also receives the active width and height. The block counts columns and rows from these strobes and splits the picture into a 16x16 grid of bands. It finds the band edges by accumulating width/16 and height/16, so it needs no divider. It then picks a colour for each band.

The card has a white border, tall saturated bars, a narrow row of mirrored bars, wide lower blocks, and a row of smooth red, green, blue and gray ramps. The ramp comes from a fractional accumulator. The step of that accumulator tunes itself, one unit per line, toward 2^FRACB/width. Each output pixel is a registered RGB word of 3×BPC bits, with red in the top bits, green in the middle and blue in the bottom bits.

Top module: `colour_bar_source`

## Requirements
- R1: While reset is high and right after it, `pixel` is 0 and `rampStep` is 1.
- R2: Column counting:
  - A line starts with column count 0, column band 0 and column edge width>>4.
  - Each take cycle without end-of-line advances the column count.
  - If the count is already at or above the edge, the band also rises by one (saturating at 15) and the edge grows by width>>4.
  - End-of-line clears all three and takes priority over take.
- R3: Row counting:
  - End-of-line advances the row count only if a pixel was taken since the last line or frame boundary; the end-of-line cycle itself counts.
  - The row band follows the same edge accumulation using height>>4.
  - End-of-frame clears the row count, the row band and the taken flag.
- R4: Row band 0, 13 and 15 are black. Bands 1–8 show the tall bars, 9 the mirrored bars, 10–12 the lower blocks and 14 the ramps.
- R5: Tall bars by column band:
  - 0 and 15 black; 1–2 white; 3–4 yellow (red+green); 5–6 cyan (green+blue); 7–8 green; 9–10 magenta (red+blue); 11–12 red; 13–14 blue.
  - A lit channel carries full scale minus floor(full scale/4), which is 12 at BPC=4.
  - The pixel word is {red, green, blue}.
- R6: In row band 9, column band c shows the tall-bar colour of column 15−c. In bands 10–12, column band bits [3:2] pick the colour: 0 full white, 2 all channels at the bar level, 1 and 3 black.
- R7: A taken pixel is full white (all ones) if any of these holds:
  - it is on the end-of-line cycle;
  - its column count is 0;
  - its row count is 0 or height−1.
- R8: Gradient row (band 14):
  - Pixel k of a line uses accumulator value a = k·step mod 2^FRACB. The accumulator clears at end-of-line and adds the step on each take.
  - g = a[FRACB-1:FRACB-4] picks the column, and L is the next BPC−1 bits of a.
  - Red is {0,L} at g=1 and {1,L} at g=2. Green does the same at g=4 and 5, and blue at g=7 and 8.
  - At g=10–13 all three channels take {g−10 as 2 bits, next BPC−2 bits of a}.
  - Every other g is black.
- R9: At end-of-line, let S be the accumulator including that cycle's take, modulo 2^FRACB. If S is nonzero:
  - the step rises by 1 when S < 2^FRACB − width;
  - otherwise it falls by 1 when S < width;
  - otherwise it holds.
  - A line end with S = 0 leaves the step unchanged.
- R10: One clock after `width` differs from its value on the previous clock, `rampStep` is 1.
- R11: Starting from step 1 with a fixed width, `rampStep` is within ±1 of 2^FRACB/width after at most 2^FRACB/width consumed lines.
- R12: `pixel` changes only on the clock edge after a take cycle and holds its value through any cycle without take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| take | input | 1 | Display consumes the current pixel |
| lineEnd | input | 1 | Last pixel of a line (or a blank line end) |
| frameEnd | input | 1 | Last pixel of the frame |
| width | input | WW | Active pixels per line |
| height | input | HW | Active lines per frame |
| pixel | output | 3*BPC | Registered {red, green, blue} pixel |
| rampStep | output | FRACB | Current gradient step |

## Verification
The bench goes after the following corner cases, each with the failure it exposes:
- End-of-line arriving on a take cycle. A design that let take win would push the band counters past 15 or shift every band.
- A line end with no consumed pixel. A design that counted it would move every row band down.
- A height small enough to saturate the row band at 15. A design that wraps would paint the bottom rows as row band 0.
- A stall in the middle of a line. A design that changed the pixel or advanced the column there would smear one column.
- Step tuning. The bench predicts the next step from each line's sum and checks that the step settles within ±1 of 2^FRACB/width. A sign or limit error would show as a runaway or stuck step.
- A width change. The bench checks that the step restarts at 1.

// File: rtl/cbar_pkg.sv
package cbar_pkg;

  typedef enum logic [2:0] {
    HUE_BLACK, HUE_WHITE, HUE_YELLOW, HUE_CYAN,
    HUE_GREEN, HUE_MAGENTA, HUE_RED, HUE_BLUE
  } barHue_t;

  // Strobes and band state handed from control to datapath
  typedef struct packed {
    logic       take;
    logic       lineEnd;
    logic [3:0] colBand;
    logic [3:0] rowBand;
    logic       border;
  } cbarCtl_t;

  function automatic barHue_t tallBarHue(input logic [3:0] col);
    case (col)
      4'd1, 4'd2:   return HUE_WHITE;
      4'd3, 4'd4:   return HUE_YELLOW;
      4'd5, 4'd6:   return HUE_CYAN;
      4'd7, 4'd8:   return HUE_GREEN;
      4'd9, 4'd10:  return HUE_MAGENTA;
      4'd11, 4'd12: return HUE_RED;
      4'd13, 4'd14: return HUE_BLUE;
      default:      return HUE_BLACK;
    endcase
  endfunction

  // {red, green, blue} channel enables for a hue
  function automatic logic [2:0] hueMask(input barHue_t hue);
    case (hue)
      HUE_WHITE:   return 3'b111;
      HUE_YELLOW:  return 3'b110;
      HUE_CYAN:    return 3'b011;
      HUE_GREEN:   return 3'b010;
      HUE_MAGENTA: return 3'b101;
      HUE_RED:     return 3'b100;
      HUE_BLUE:    return 3'b001;
      default:     return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/cbar_ctrl.sv
module cbar_ctrl
  import cbar_pkg::*;
#(
  parameter int WW = 10,
  parameter int HW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          lineEnd,
  input  logic          frameEnd,
  input  logic [WW-1:0] width,
  input  logic [HW-1:0] height,
  output cbarCtl_t      ctl
);
  localparam int CEW = WW + 1;
  localparam int REW = HW + 1;

  logic [WW-1:0]  colCnt;
  logic [CEW-1:0] colEdge;
  logic [3:0]     colBand;
  logic [HW-1:0]  rowCnt;
  logic [REW-1:0] rowEdge;
  logic [3:0]     rowBand;
  logic           seenPix;

  logic [CEW-1:0] colStep;
  logic [REW-1:0] rowStep;
  logic           unusedWidthLow;

  assign colStep        = CEW'(width >> 4);
  assign rowStep        = REW'(height >> 4);
  assign unusedWidthLow = ^width[3:0];

  // Column count and column band
  always_ff @(posedge clk) begin
    if (rst || lineEnd) begin
      colCnt  <= '0;
      colBand <= '0;
      colEdge <= colStep;
    end else if (take) begin
      colCnt <= colCnt + 1'b1;
      if (CEW'(colCnt) >= colEdge) begin
        if (colBand != 4'hF) colBand <= colBand + 1'b1;
        colEdge <= colEdge + colStep;
      end
    end
  end

  // Row count and row band, advanced only by lines that carried pixels
  always_ff @(posedge clk) begin
    if (rst || frameEnd) begin
      rowCnt  <= '0;
      rowBand <= '0;
      rowEdge <= rowStep;
      seenPix <= 1'b0;
    end else if (lineEnd) begin
      if (seenPix || take) begin
        rowCnt <= rowCnt + 1'b1;
        if (REW'(rowCnt) >= rowEdge) begin
          if (rowBand != 4'hF) rowBand <= rowBand + 1'b1;
          rowEdge <= rowEdge + rowStep;
        end
      end
      seenPix <= 1'b0;
    end else if (take) begin
      seenPix <= 1'b1;
    end
  end

  always_comb begin
    ctl.take    = take;
    ctl.lineEnd = lineEnd;
    ctl.colBand = colBand;
    ctl.rowBand = rowBand;
    ctl.border  = lineEnd || (colCnt == '0) || (rowCnt == '0) ||
                  (rowCnt == height - 1'b1);
  end

  // R2: a line end always restarts the column band
  p_col_clear_r2: assert property (@(posedge clk) disable iff (rst)
    lineEnd |=> (colBand == 4'd0));

  // R2: the column band moves by at most one per take
  p_col_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!lineEnd && take) |=> (colBand == $past(colBand)) || (colBand == $past(colBand) + 4'd1));

  // R3: a line end without any consumed pixel does not count as a row
  p_row_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (lineEnd && !frameEnd && !take && !seenPix) |=> $stable(rowCnt));

  // R3: frame end restarts the rows
  p_row_clear_r3: assert property (@(posedge clk) disable iff (rst)
    frameEnd |=> (rowCnt == '0) && (rowBand == 4'd0));

endmodule

// File: rtl/cbar_datapath.sv
module cbar_datapath
  import cbar_pkg::*;
#(
  parameter int WW    = 10,
  parameter int BPC   = 4,
  parameter int FRACB = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  cbarCtl_t         ctl,
  input  logic [WW-1:0]    width,
  output logic [3*BPC-1:0] pixel,
  output logic [FRACB-1:0] rampStep
);
  localparam int                 PW    = 3 * BPC;
  localparam int                 SW    = FRACB + 1;
  localparam logic [BPC-1:0]     FULLV = {BPC{1'b1}};
  localparam logic [BPC-1:0]     BARV  = FULLV - (FULLV >> 2);
  localparam logic [SW-1:0]      SPAN  = SW'(1) << FRACB;

  logic [FRACB-1:0] acc, accSum, step;
  logic [WW-1:0]    widthPrev;
  logic [SW-1:0]    shortLimit;

  assign accSum     = ctl.take ? acc + step : acc;
  assign shortLimit = SPAN - SW'(width);
  assign rampStep   = step;

  always_ff @(posedge clk) begin
    if (rst || ctl.lineEnd) acc <= '0;
    else if (ctl.take)      acc <= acc + step;
  end

  // Step tuning toward 2^FRACB/width, one unit per line
  always_ff @(posedge clk) begin
    widthPrev <= width;
    if (rst || (width != widthPrev)) begin
      step <= FRACB'(1);
    end else if (ctl.lineEnd && (accSum != '0)) begin
      if (SW'(accSum) < shortLimit)       step <= step + 1'b1;
      else if (accSum < FRACB'(width))    step <= step - 1'b1;
    end
  end

  // Colour selection
  logic [3:0]     gCol, grayIdx;
  logic [BPC-2:0] rampLow;
  logic [BPC-3:0] grayLow;
  logic [BPC-1:0] red, grn, blu, grayV;
  logic [2:0]     tallMask, mirrorMask;
  logic           unusedAcc;

  assign gCol       = acc[FRACB-1 -: 4];
  assign rampLow    = acc[FRACB-5 -: BPC-1];
  assign grayLow    = acc[FRACB-5 -: BPC-2];
  assign grayIdx    = gCol - 4'd10;
  assign grayV      = {grayIdx[1:0], grayLow};
  assign tallMask   = hueMask(tallBarHue(ctl.colBand));
  assign mirrorMask = hueMask(tallBarHue(~ctl.colBand));
  assign unusedAcc  = ^acc;

  always_comb begin
    red = '0; grn = '0; blu = '0;
    if (ctl.border) begin
      red = FULLV; grn = FULLV; blu = FULLV;
    end else begin
      case (ctl.rowBand)
        4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8: begin
          red = tallMask[2] ? BARV : '0;
          grn = tallMask[1] ? BARV : '0;
          blu = tallMask[0] ? BARV : '0;
        end
        4'd9: begin
          red = mirrorMask[2] ? BARV : '0;
          grn = mirrorMask[1] ? BARV : '0;
          blu = mirrorMask[0] ? BARV : '0;
        end
        4'd10, 4'd11, 4'd12: begin
          case (ctl.colBand[3:2])
            2'd0:    begin red = FULLV; grn = FULLV; blu = FULLV; end
            2'd2:    begin red = BARV;  grn = BARV;  blu = BARV;  end
            default: ;
          endcase
        end
        4'd14: begin
          case (gCol)
            4'd1:  red = {1'b0, rampLow};
            4'd2:  red = {1'b1, rampLow};
            4'd4:  grn = {1'b0, rampLow};
            4'd5:  grn = {1'b1, rampLow};
            4'd7:  blu = {1'b0, rampLow};
            4'd8:  blu = {1'b1, rampLow};
            4'd10, 4'd11, 4'd12, 4'd13: begin
              red = grayV; grn = grayV; blu = grayV;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           pixel <= '0;
    else if (ctl.take) pixel <= {red, grn, blu};
  end

  // R12: no take, no pixel change
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !ctl.take |=> $stable(pixel));

  // R7: the end-of-line pixel is white
  p_white_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl.take && ctl.lineEnd) |=> (pixel == {PW{1'b1}}));

  // R9: the step only moves at a line end or on a width change
  p_step_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ((width == widthPrev) && !ctl.lineEnd) |=> $stable(step));

  // R10: a width change restarts the step
  p_step_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (width != widthPrev) |=> (step == FRACB'(1)));

endmodule

// File: rtl/colour_bar_source.sv
module colour_bar_source
  import cbar_pkg::*;
#(
  parameter int WW    = 10,
  parameter int HW    = 10,
  parameter int BPC   = 4,
  parameter int FRACB = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             lineEnd,
  input  logic             frameEnd,
  input  logic [WW-1:0]    width,
  input  logic [HW-1:0]    height,
  output logic [3*BPC-1:0] pixel,
  output logic [FRACB-1:0] rampStep
);
  if (FRACB <= WW + BPC) begin : g_badCfg
    $error("FRACB must exceed WW + BPC");
  end

  cbarCtl_t ctl;

  cbar_ctrl #(.WW(WW), .HW(HW)) u_ctrl (
    .clk(clk), .rst(rst), .take(take), .lineEnd(lineEnd),
    .frameEnd(frameEnd), .width(width), .height(height), .ctl(ctl)
  );

  cbar_datapath #(.WW(WW), .BPC(BPC), .FRACB(FRACB)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .width(width),
    .pixel(pixel), .rampStep(rampStep)
  );

endmodule

// File: tb/sim_colour_bar_source.sv
`timescale 1ns/1ps
module sim_colour_bar_source;
  localparam int WW = 10, HW = 10, BPC = 4, FRACB = 15;
  localparam int SPAN = 1 << FRACB;
  localparam int NMODE = 3;
  localparam int modeW [NMODE] = '{96, 160, 128};
  localparam int modeH [NMODE] = '{40, 48, 20};

  logic clk = 1'b0;
  logic rst, take, lineEnd, frameEnd;
  logic [WW-1:0] width;
  logic [HW-1:0] height;
  logic [3*BPC-1:0] pixel;
  logic [FRACB-1:0] rampStep;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  colour_bar_source #(.WW(WW), .HW(HW), .BPC(BPC), .FRACB(FRACB)) u0 (
    .clk(clk), .rst(rst), .take(take), .lineEnd(lineEnd), .frameEnd(frameEnd),
    .width(width), .height(height), .pixel(pixel), .rampStep(rampStep)
  );

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int bandOf(input int n, input int d);
    int bar = 0;
    int edgeV = d >> 4;
    for (int i = 0; i < n; i++) begin
      if (i >= edgeV) begin
        if (bar < 15) bar++;
        edgeV += d >> 4;
      end
    end
    return bar;
  endfunction

  function automatic int mk(input int r, input int g, input int b);
    return (r << 8) | (g << 4) | b;
  endfunction

  function automatic int tallBar(input int c);
    case (c)
      1, 2:   return mk(12, 12, 12);
      3, 4:   return mk(12, 12, 0);
      5, 6:   return mk(0, 12, 12);
      7, 8:   return mk(0, 12, 0);
      9, 10:  return mk(12, 0, 12);
      11, 12: return mk(12, 0, 0);
      13, 14: return mk(0, 0, 12);
      default: return 0;
    endcase
  endfunction

  function automatic int expPix(input int k, input int j, input int w, input int h,
                                input int s, output string tag);
    int cb, rb, acc, g, lo3, lo2, v;
    cb = bandOf(k, w);
    rb = bandOf(j, h);
    if (k == 0 || k == w - 1 || j == 0 || j == h - 1) begin
      tag = "R7 border";
      return 12'hFFF;
    end
    if (rb >= 1 && rb <= 8) begin
      tag = "R5 tall bars (R2 R3 bands)";
      return tallBar(cb);
    end
    if (rb == 9) begin
      tag = "R6 mirrored bars";
      return tallBar(15 - cb);
    end
    if (rb >= 10 && rb <= 12) begin
      tag = "R6 lower blocks";
      case (cb >> 2)
        0: return 12'hFFF;
        2: return mk(12, 12, 12);
        default: return 0;
      endcase
    end
    if (rb == 14) begin
      tag = "R8 gradient";
      acc = (k * s) % SPAN;
      g = acc >> 11;
      lo3 = (acc >> 8) & 7;
      lo2 = (acc >> 9) & 3;
      case (g)
        1: return mk(lo3, 0, 0);
        2: return mk(8 + lo3, 0, 0);
        4: return mk(0, lo3, 0);
        5: return mk(0, 8 + lo3, 0);
        7: return mk(0, 0, lo3);
        8: return mk(0, 0, 8 + lo3);
        10, 11, 12, 13: begin
          v = ((g - 10) << 2) | lo2;
          return mk(v, v, v);
        end
        default: return 0;
      endcase
    end
    tag = "R4 black rows";
    return 0;
  endfunction

  task automatic runLine(input int j, input int w, input int h, input bit last);
    int s, e, sum, ns;
    int prevExp = 0;
    string tag;
    s = int'(rampStep);
    for (int k = 0; k < w; k++) begin
      if (k == 5) begin
        @(negedge clk); take = 0; lineEnd = 0; frameEnd = 0;
        @(posedge clk); #1;
        chk("R12 stall holds pixel", int'(pixel), prevExp);
      end
      @(negedge clk);
      take = 1; lineEnd = (k == w - 1); frameEnd = last && (k == w - 1);
      @(posedge clk); #1;
      e = expPix(k, j, w, h, s, tag);
      chk(tag, int'(pixel), e);
      prevExp = e;
    end
    @(negedge clk); take = 0; lineEnd = 0; frameEnd = 0;
    sum = (w * s) % SPAN;
    ns = s;
    if (sum != 0) begin
      if (sum < SPAN - w) ns = s + 1;
      else if (sum < w) ns = s - 1;
    end
    @(posedge clk); #1;
    chk("R9 step update", int'(rampStep), ns);
    @(negedge clk);
    @(posedge clk); #1;
    chk("R12 idle holds pixel", int'(pixel), prevExp);
  endtask

  task automatic runFrame(input int w, input int h, input bit blank);
    int sBefore;
    for (int j = 0; j < h; j++) begin
      runLine(j, w, h, j == h - 1);
      if (blank && j == 2) begin
        sBefore = int'(rampStep);
        @(negedge clk); lineEnd = 1; take = 0;
        @(posedge clk); #1;
        chk("R9 zero-sum line end keeps step", int'(rampStep), sBefore);
        @(negedge clk); lineEnd = 0;
      end
    end
  endtask

  task automatic setMode(input int w, input int h);
    @(negedge clk);
    width = WW'(w); height = HW'(h); take = 0; lineEnd = 0; frameEnd = 0;
    @(posedge clk); #1;
    chk("R10 width change restarts step", int'(rampStep), 1);
    @(negedge clk); lineEnd = 1; frameEnd = 1;
    @(posedge clk); #1;
    @(negedge clk); lineEnd = 0; frameEnd = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired before the run ended");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int diff;
    rst = 1; take = 0; lineEnd = 0; frameEnd = 0;
    width = WW'(128); height = HW'(64);
    repeat (4) @(posedge clk);
    #1;
    chk("R1 reset pixel", int'(pixel), 0);
    chk("R1 reset step", int'(rampStep), 1);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk("R1 pixel after reset", int'(pixel), 0);
    chk("R1 step after reset", int'(rampStep), 1);

    // 256 lines = 2^FRACB/width for width 128
    for (int f = 0; f < 4; f++) runFrame(128, 64, 1'b0);
    diff = int'(rampStep) - (SPAN / 128);
    if (diff < 0) diff = -diff;
    chk("R11 step converged within one of target", (diff <= 1) ? 1 : 0, 1);

    for (int m = 0; m < NMODE; m++) begin
      setMode(modeW[m], modeH[m]);
      runFrame(modeW[m], modeH[m], 1'b1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule